// File: doc/BRIEF.md
# I2C Memory Read Slave

This block is the bus-facing half of a serial memory on a two-wire I2C bus. It oversamples the bus clock and data lines with the system clock, detects start, repeated start and stop conditions, and decodes the device address byte. It drives the data line only through an open-drain pull-down enable. One sixteen-bit address counter serves every read mode. A current-address read returns the byte at the counter. A random read first sends the word address in a dummy write and then reads after a repeated start. A stop after the word address, instead of a repeated start, only moves the counter. A sequential read streams consecutive bytes and wraps from the last address to the first.

Array data comes from an external synchronous memory. The block pulses a read enable with the counter value on the address port and latches the returned byte on the following clock. A busy input, raised while a nonvolatile write is in progress, makes the slave ignore its own device address so that the master can poll. Writing data into the array is not part of this block.

Top module: `i2c_mem_rd_slave`

## Requirements
- R1: After reset the address counter (seen on `mem_addr`) is 0 and `sda_oe` is low, so the first current-address read returns the byte at address 0.
- R2: The slave acknowledges a device byte whose upper seven bits equal `DEV_ADDR` (default 7'h57: byte AEh with bit 0 = 0 selects write, AFh with bit 0 = 1 selects read). Any other device byte gets no acknowledge, and the slave stays released until the next start.
- R3: For a read, the slave acknowledges and then shifts out eight bits MSB first from the counter address. The counter advances by one after each byte sent. `mem_rd_en` is a one-cycle pulse.
- R4: If the master leaves SDA high on the ninth clock of a read byte, the slave stops driving. It keeps SDA released for any further clocks until a start or stop.
- R5: In a write-mode access the slave acknowledges two word-address bytes, high byte first. A repeated start with a read device byte then returns the byte at that word address.
- R6: A stop after both word-address bytes keeps the loaded address in the counter. Clocked bytes that follow without a start get no acknowledge.
- R7: The counter takes the word address only when the second address byte has been acknowledged. A stop after only the first byte leaves the counter unchanged.
- R8: Each master acknowledge on the ninth clock of a read byte makes the slave send the byte at the next address. The counter wraps from FFFFh to 0000h and output continues.
- R9: While `busy_i` is high at the end of the device byte, the slave does not acknowledge it.
- R10: `sda_oe` rises only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| busy_i | input | 1 | High while a nonvolatile write is in progress |
| sda_oe | output | 1 | High pulls the data line low |
| mem_rd_en | output | 1 | One-cycle read request to the memory |
| mem_addr | output | AW | Current address counter |
| mem_rd_data | input | 8 | Memory data, valid the cycle after `mem_rd_en` |

## Verification
The bench runs a sequential read across the top of the array and checks the byte after FFFFh. A counter that saturated or stopped there would repeat the last byte or send nothing. It ends a set-current-address transfer with a stop after only the high address byte. A design that loaded the counter byte by byte would then read from a corrupted address. After a master no-acknowledge it keeps clocking data bits. A slave that went on shifting would pull the line low during that idle traffic. It also clocks a full read device byte with no start in front of it, after a stop, and a slave that did not wait for a start would acknowledge it.

// File: rtl/i2c_mem_rd_slave.sv
module i2c_mem_rd_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h57,
  parameter int         AW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          busy_i,
  output logic          sda_oe,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rd_data
);

  localparam int NAB = AW / 8;
  localparam int ABW = (NAB > 1) ? $clog2(NAB) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_ADR, S_AACK, S_HOLD, S_RD, S_RACK, S_RPRE
  } st_t;

  st_t            st;
  logic [2:0]     scl_sr, sda_sr;
  logic [3:0]     bcnt;
  logic [6:0]     rx;
  logic [7:0]     tx;
  logic           rw, ack_on, rd_pend;
  logic [ABW-1:0] abyte;
  logic [AW-1:0]  addr_sr, cnt;

  wire scl_syn  = scl_sr[1];
  wire scl_old  = scl_sr[2];
  wire sda_syn  = sda_sr[1];
  wire sda_old  = sda_sr[2];
  wire scl_rise = scl_syn & ~scl_old;
  wire scl_fall = ~scl_syn & scl_old;
  wire start_c  = scl_syn & scl_old & sda_old & ~sda_syn;
  wire stop_c   = scl_syn & scl_old & ~sda_old & sda_syn;
  wire [7:0] rx_byte = {rx, sda_syn};
  wire cnt_load = (st == S_AACK) && ack_on && scl_fall &&
                  (abyte == ABW'(NAB - 1)) && !start_c && !stop_c;

  assign mem_addr = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bcnt      <= '0;
      rx        <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      ack_on    <= 1'b0;
      rd_pend   <= 1'b0;
      abyte     <= '0;
      addr_sr   <= '0;
      cnt       <= '0;
      sda_oe    <= 1'b0;
      mem_rd_en <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      rd_pend   <= mem_rd_en;
      if (rd_pend) tx <= mem_rd_data;

      if (start_c) begin
        st     <= S_DEV;
        bcnt   <= '0;
        sda_oe <= 1'b0;
        ack_on <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        ack_on <= 1'b0;
      end else begin
        unique case (st)
          S_DEV: if (scl_rise) begin
            rx   <= rx_byte[6:0];
            bcnt <= bcnt + 4'd1;
            if (bcnt == 4'd7) begin
              bcnt <= '0;
              if (rx_byte[7:1] == DEV_ADDR && !busy_i) begin
                st <= S_DACK;
                rw <= rx_byte[0];
                if (rx_byte[0]) mem_rd_en <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end

          S_DACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              bcnt   <= '0;
              if (rw) begin
                sda_oe <= ~tx[7];
                st     <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                abyte  <= '0;
                st     <= S_ADR;
              end
            end
          end

          S_ADR: if (scl_rise) begin
            rx   <= rx_byte[6:0];
            bcnt <= bcnt + 4'd1;
            if (bcnt == 4'd7) begin
              bcnt    <= '0;
              addr_sr <= {addr_sr[AW-9:0], rx_byte};
              st      <= S_AACK;
            end
          end

          S_AACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              sda_oe <= 1'b0;
              if (cnt_load) begin
                cnt <= addr_sr;
                st  <= S_HOLD;
              end else begin
                abyte <= abyte + ABW'(1);
                st    <= S_ADR;
              end
            end
          end

          S_RD: begin
            if (scl_rise) begin
              bcnt <= bcnt + 4'd1;
              if (bcnt == 4'd7) cnt <= cnt + AW'(1);
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0;
                bcnt   <= '0;
                st     <= S_RACK;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[6:0], 1'b0};
              end
            end
          end

          S_RACK: if (scl_rise) begin
            if (!sda_syn) begin
              mem_rd_en <= 1'b1;
              st        <= S_RPRE;
            end else begin
              st <= S_IDLE;
            end
          end

          S_RPRE: if (scl_fall) begin
            sda_oe <= ~tx[7];
            bcnt   <= '0;
            st     <= S_RD;
          end

          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_mem_rd_slave_chk.sv
module i2c_mem_rd_slave_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_syn,
  input logic          sda_oe,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr,
  input logic          cnt_load
);

  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  // R1
  always_ff @(posedge clk)
    if (was_rst)
      rst_state_chk: assert (mem_addr == '0 && !sda_oe)
        else $error("counter or data drive not clear after reset");

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_addr == $past(mem_addr) + AW'(1)) || $past(cnt_load));

  // R10
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_syn));

endmodule

bind i2c_mem_rd_slave i2c_mem_rd_slave_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_syn(scl_syn), .sda_oe(sda_oe),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .cnt_load(cnt_load)
);

// File: tb/i2c_mem_rd_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_rd_slave_tb_top;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic sda_oe, mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rd_data = '0;
  wire sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0, oe_viol = 0;
  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];
  logic       oe_prev = 1'b0;

  always #2 clk = ~clk;

  i2c_mem_rd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .busy_i(busy),
    .sda_oe(sda_oe), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hC3;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_addr);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0 && act_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic logic [7:0] a = act_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(a == e, t, a, e);
    end
  end

  // R10: data drive must rise only while the bus clock is low
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && m_scl) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(Q);
    s = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic expect_rd(input logic [15:0] a, input string tag);
    exp_q.push_back(pat(a));
    tag_q.push_back(tag);
  endtask

  task automatic read_byte(input logic mack);
    logic s;
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(!mack, s);
    act_q.push_back(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack, s;
    tick(5);
    // R1 reset state
    chk(!sda_oe && !mem_rd_en, "R1 reset outputs", {sda_oe, mem_rd_en}, 0);
    rst_n = 1'b1;
    tick(5);

    // current-address read right after reset
    i2c_start(); send_byte(8'hAF, ack);
    chk(ack, "R2 read device byte ack", ack, 1);
    expect_rd(16'h0000, "R1 R3 first byte from address 0");
    read_byte(1'b0);
    // R4: idle clocks after no-ack must see the line released
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      chk(s && !sda_oe, "R4 released after master no-ack", s, 1);
    end
    i2c_stop();

    // R3 counter advanced
    i2c_start(); send_byte(8'hAF, ack);
    expect_rd(16'h0001, "R3 counter advanced");
    read_byte(1'b0); i2c_stop();

    // random read then sequential
    i2c_start(); send_byte(8'hAE, ack);
    chk(ack, "R2 write device byte ack", ack, 1);
    send_byte(8'h12, ack); chk(ack, "R5 high address ack", ack, 1);
    send_byte(8'h34, ack); chk(ack, "R5 low address ack", ack, 1);
    i2c_start(); send_byte(8'hAF, ack);
    chk(ack, "R5 repeated start read ack", ack, 1);
    expect_rd(16'h1234, "R5 random read");
    read_byte(1'b1);
    expect_rd(16'h1235, "R8 sequential n+1");
    read_byte(1'b1);
    expect_rd(16'h1236, "R8 sequential n+2");
    read_byte(1'b0); i2c_stop();

    // set current address, then unaddressed traffic
    i2c_start(); send_byte(8'hAE, ack);
    send_byte(8'hFF, ack); send_byte(8'hFE, ack);
    chk(ack, "R6 set address ack", ack, 1);
    i2c_stop();
    send_byte(8'hAF, ack);
    chk(!ack, "R6 ignored without start", ack, 0);
    i2c_stop();
    i2c_start(); send_byte(8'hAF, ack);
    expect_rd(16'hFFFE, "R6 read from set address");
    read_byte(1'b1);
    expect_rd(16'hFFFF, "R8 last address");
    read_byte(1'b1);
    expect_rd(16'h0000, "R8 wrap to zero");
    read_byte(1'b0); i2c_stop();

    // R7: stop after only the high address byte
    i2c_start(); send_byte(8'hAE, ack);
    send_byte(8'h55, ack); i2c_stop();
    i2c_start(); send_byte(8'hAF, ack);
    expect_rd(16'h0001, "R7 counter kept after partial address");
    read_byte(1'b0); i2c_stop();

    // R2 wrong device address
    i2c_start(); send_byte(8'hA0, ack);
    chk(!ack, "R2 foreign address no ack", ack, 0);
    i2c_stop();

    // R9 busy
    busy = 1'b1;
    i2c_start(); send_byte(8'hAF, ack);
    chk(!ack, "R9 busy no ack", ack, 0);
    i2c_stop();
    busy = 1'b0;
    i2c_start(); send_byte(8'hAF, ack);
    chk(ack, "R9 ack after busy clears", ack, 1);
    expect_rd(16'h0002, "R9 read after poll");
    read_byte(1'b0); i2c_stop();

    tick(10);
    chk(oe_viol == 0, "R10 drive rose with SCL high", oe_viol, 0);
    chk(exp_q.size() == 0 && act_q.size() == 0, "R3 scoreboard drained",
        exp_q.size() + act_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule